// File: doc/BRIEF.md
# Card Information Tuple Scanner

This block searches the card information chain that a removable card keeps in its memory for one tuple code. A tuple is stored as a code byte, then a link byte, then a body whose length in bytes equals the link value. The following tuple begins at the current logical position plus two plus the link value. When a start pulse arrives, the scanner walks this chain through a synchronous byte-read memory port. It searches attribute space first and then common space. On the first matching code it copies the leading body bytes into an output buffer.

In attribute space only even physical bytes carry data, so logical position p is fetched from physical address 2p. In common space the physical address equals the logical position. Three conditions end the walk in a space: an end marker in either the code or the link byte, a tuple-count limit, and the edge of the region. Only one read is in flight at a time. What a tuple body means is left to the consumer.

The controller has eight states:
- `ST_IDLE` waits for a start pulse.
- `ST_CODE_REQ` and `ST_CODE_CHK` fetch the code byte and test it.
- `ST_LINK_REQ` and `ST_LINK_CHK` fetch the link byte, test it and decide between match and skip.
- `ST_BODY_REQ` and `ST_BODY_CAP` copy body bytes one at a time.
- `ST_DONE` raises the completion pulse.

The transitions are as follows:
- start: `ST_IDLE` to `ST_CODE_REQ`.
- code fetch: `ST_CODE_REQ` to `ST_CODE_CHK`.
- code accepted: `ST_CODE_CHK` to `ST_LINK_REQ`.
- link fetch: `ST_LINK_REQ` to `ST_LINK_CHK`.
- skip: `ST_LINK_CHK` to `ST_CODE_REQ`.
- match: `ST_LINK_CHK` to `ST_BODY_REQ`, or to `ST_DONE` when the copy length is zero.
- body fetch: `ST_BODY_REQ` to `ST_BODY_CAP`.
- next byte: `ST_BODY_CAP` to `ST_BODY_REQ`.
- copy complete: `ST_BODY_CAP` to `ST_DONE`.
- region truncation: `ST_BODY_REQ` to `ST_DONE`.
- space exhausted: `ST_CODE_REQ`, `ST_CODE_CHK`, `ST_LINK_REQ` or `ST_LINK_CHK` go to `ST_CODE_REQ` in common space if the search was in attribute space, otherwise to `ST_DONE`.
- release: `ST_DONE` to `ST_IDLE`.

Top module: `cis_tuple_scan`

## Requirements
- R1: The tuple at logical position p has its code at p, its link at p+1 and its body from p+2. A non-matching tuple is skipped to position p+2+link.
- R2: A code byte of 0xFF ends the search in the current space. A link byte of 0xFF also ends it, even when the code byte matches the sought code.
- R3: With `mem_space`=1 (attribute space), logical position p is read at physical address 2p, so every attribute read address is even. With `mem_space`=0 (common space), the physical address equals p.
- R4: The search starts in attribute space at position 0. If attribute space yields no match, it restarts in common space at position 0.
- R5: At most MAX_TUPLES tuples are examined in each space. The tuple at index MAX_TUPLES-1 (counting from 0) can still match; the next tuple is never read.
- R6: No read targets a logical position at or beyond REGION_BYTES. A walk that would need such a position ends the space, and a body copy that reaches it stops with the bytes copied so far.
- R7: On a match, `found`=1 and `count` = min(link, request, MAX_LEN). Here request is `max_len` clamped to MAX_LEN. Body byte k appears at `buf_data[8k+7:8k]`, and the bytes at index `count` and above read zero.
- R8: When neither space matches, the scan completes with `found`=0 and `count`=0.
- R9: `done` is high for exactly one cycle per scan. `busy` is high from the cycle after the start pulse until `done`. `found`, `count` and `buf_data` hold until the next accepted start.
- R10: A start pulse while `busy` is high is ignored, and the running scan completes with its original code and limit.
- R11: At most one read is outstanding at a time: `mem_rd_en` is never high in two consecutive cycles. `mem_rdata` is taken in the cycle after the request.
- R12: After reset, `done`, `busy`, `found`, `count` and `mem_rd_en` are 0 and `buf_data` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a scan |
| want_code | input | 8 | Tuple code sought |
| max_len | input | LEN_W | Maximum body bytes to copy |
| mem_rd_en | output | 1 | Byte read request |
| mem_space | output | 1 | 1 = attribute space, 0 = common space |
| mem_addr | output | ADDR_W | Physical byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| done | output | 1 | Scan-complete pulse |
| busy | output | 1 | Scan in progress |
| found | output | 1 | A matching tuple was found |
| count | output | LEN_W | Body bytes copied |
| buf_data | output | 8*MAX_LEN | Copied body bytes, byte 0 in the low bits |

## Verification
The bench's memory returns a junk byte for odd attribute addresses, so a wrong stride corrupts codes and data. Placing the target first, mid-chain or only in common space separates plain matching from chain skipping and from the space fallback. A tuple whose code matches but whose link is 0xFF shows whether the link end marker is honoured ahead of the match. Chains sized to hit the tuple limit exactly, to land beyond the region, or to overrun the region in the body check the three bounds. Request lengths of zero, below the link and above MAX_LEN check the copy count.

// File: rtl/cis_scan_pkg.sv
package cis_scan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CODE_REQ,
        ST_CODE_CHK,
        ST_LINK_REQ,
        ST_LINK_CHK,
        ST_BODY_REQ,
        ST_BODY_CAP,
        ST_DONE
    } scan_state_e;

    localparam logic [7:0] CHAIN_END = 8'hFF;
endpackage

// File: rtl/cis_addr_gen.sv
module cis_addr_gen #(
    parameter int POS_W  = 14,
    parameter int ADDR_W = 14
) (
    input  logic [POS_W-1:0]  pos,
    input  logic              attr,
    output logic [ADDR_W-1:0] addr
);
    logic [POS_W:0] doubled;
    logic [POS_W:0] single;

    assign doubled = {pos, 1'b0};
    assign single  = {1'b0, pos};
    assign addr    = attr ? doubled[ADDR_W-1:0] : single[ADDR_W-1:0];
endmodule

// File: rtl/cis_body_buf.sv
module cis_body_buf #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [7:0]         wr_data,
    output logic [8*DEPTH-1:0] bytes_out
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bytes_out[8*i +: 8] <= '0;
            else if (clr)
                bytes_out[8*i +: 8] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))
                bytes_out[8*i +: 8] <= wr_data;
        end
    end

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < DEPTH)); // R7
endmodule

// File: rtl/cis_tuple_scan.sv
module cis_tuple_scan
    import cis_scan_pkg::*;
#(
    parameter int REGION_BYTES = 8192,
    parameter int MAX_TUPLES   = 1000,
    parameter int MAX_LEN      = 8,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int ADDR_W = $clog2(REGION_BYTES) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [7:0]           want_code,
    input  logic [LEN_W-1:0]     max_len,
    output logic                 mem_rd_en,
    output logic                 mem_space,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [7:0]           mem_rdata,
    output logic                 done,
    output logic                 busy,
    output logic                 found,
    output logic [LEN_W-1:0]     count,
    output logic [8*MAX_LEN-1:0] buf_data
);
    localparam int POS_W  = $clog2(REGION_BYTES) + 1;
    localparam int TCNT_W = $clog2(MAX_TUPLES + 1);
    localparam logic [POS_W-1:0]  REGION_END = POS_W'(REGION_BYTES);
    localparam logic [TCNT_W-1:0] TUPLE_CAP  = TCNT_W'(MAX_TUPLES);
    localparam logic [LEN_W-1:0]  LEN_CAP    = LEN_W'(MAX_LEN);

    scan_state_e state, state_n;

    logic [POS_W-1:0]  pos;
    logic [TCNT_W-1:0] tcnt;
    logic              space_attr;
    logic              hit;
    logic [7:0]        want_q;
    logic [LEN_W-1:0]  req_q;
    logic [LEN_W-1:0]  lim;
    logic [LEN_W-1:0]  bidx;
    logic              found_q;
    logic [LEN_W-1:0]  count_q;

    logic [POS_W-1:0]  pos_link;
    logic [POS_W-1:0]  pos_body;
    logic [POS_W-1:0]  pos_next;
    logic [POS_W-1:0]  rd_pos;
    logic [LEN_W-1:0]  lim_n;
    logic [LEN_W-1:0]  bidx_inc;
    logic              exhaust;
    logic              body_stop;

    assign pos_link  = pos + POS_W'(1);
    assign pos_body  = pos + POS_W'(2) + POS_W'(bidx);
    assign pos_next  = pos + POS_W'(2) + POS_W'(mem_rdata);
    assign lim_n     = (mem_rdata < 8'(req_q)) ? mem_rdata[LEN_W-1:0] : req_q;
    assign bidx_inc  = bidx + LEN_W'(1);
    assign body_stop = (pos_body >= REGION_END);

    always_comb begin
        exhaust = 1'b0;
        unique case (state)
            ST_CODE_REQ: exhaust = (pos >= REGION_END) || (tcnt == TUPLE_CAP);
            ST_CODE_CHK: exhaust = (mem_rdata == CHAIN_END);
            ST_LINK_REQ: exhaust = (pos_link >= REGION_END);
            ST_LINK_CHK: exhaust = (mem_rdata == CHAIN_END);
            default:     exhaust = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:     if (start) state_n = ST_CODE_REQ;
            ST_CODE_REQ: state_n = exhaust ? (space_attr ? ST_CODE_REQ : ST_DONE) : ST_CODE_CHK;
            ST_CODE_CHK: state_n = exhaust ? (space_attr ? ST_CODE_REQ : ST_DONE) : ST_LINK_REQ;
            ST_LINK_REQ: state_n = exhaust ? (space_attr ? ST_CODE_REQ : ST_DONE) : ST_LINK_CHK;
            ST_LINK_CHK: begin
                if (exhaust)
                    state_n = space_attr ? ST_CODE_REQ : ST_DONE;
                else if (hit)
                    state_n = (lim_n == '0) ? ST_DONE : ST_BODY_REQ;
                else
                    state_n = ST_CODE_REQ;
            end
            ST_BODY_REQ: state_n = body_stop ? ST_DONE : ST_BODY_CAP;
            ST_BODY_CAP: state_n = (bidx_inc == lim) ? ST_DONE : ST_BODY_REQ;
            ST_DONE:     state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos        <= '0;
            tcnt       <= '0;
            space_attr <= 1'b1;
            hit        <= 1'b0;
            want_q     <= '0;
            req_q      <= '0;
            lim        <= '0;
            bidx       <= '0;
            found_q    <= 1'b0;
            count_q    <= '0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                pos        <= '0;
                tcnt       <= '0;
                space_attr <= 1'b1;
                want_q     <= want_code;
                req_q      <= (max_len > LEN_CAP) ? LEN_CAP : max_len;
                found_q    <= 1'b0;
                count_q    <= '0;
            end
        end else if (exhaust) begin
            if (space_attr) begin
                space_attr <= 1'b0;
                pos        <= '0;
                tcnt       <= '0;
            end else begin
                found_q <= 1'b0;
                count_q <= '0;
            end
        end else begin
            unique case (state)
                ST_CODE_CHK: hit <= (mem_rdata == want_q);
                ST_LINK_CHK: begin
                    if (hit) begin
                        found_q <= 1'b1;
                        count_q <= '0;
                        lim     <= lim_n;
                        bidx    <= '0;
                    end else begin
                        pos  <= pos_next;
                        tcnt <= tcnt + TCNT_W'(1);
                    end
                end
                ST_BODY_CAP: begin
                    bidx    <= bidx_inc;
                    count_q <= bidx_inc;
                end
                default: ;
            endcase
        end
    end

    cis_body_buf #(.DEPTH(MAX_LEN), .IDX_W(LEN_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state == ST_IDLE && start),
        .wr_en    (state == ST_BODY_CAP),
        .wr_idx   (bidx),
        .wr_data  (mem_rdata),
        .bytes_out(buf_data)
    );

    // outputs
    always_comb begin
        mem_rd_en = 1'b0;
        rd_pos    = pos;
        unique case (state)
            ST_CODE_REQ: mem_rd_en = !exhaust;
            ST_LINK_REQ: begin mem_rd_en = !exhaust; rd_pos = pos_link; end
            ST_BODY_REQ: begin mem_rd_en = !body_stop; rd_pos = pos_body; end
            default:     mem_rd_en = 1'b0;
        endcase
        done  = (state == ST_DONE);
        busy  = (state != ST_IDLE);
        found = found_q;
        count = count_q;
    end

    assign mem_space = space_attr;

    cis_addr_gen #(.POS_W(POS_W), .ADDR_W(ADDR_W)) u_addr (
        .pos (rd_pos),
        .attr(space_attr),
        .addr(mem_addr)
    );

    AST_ATTR_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && mem_space) |-> !mem_addr[0]); // R3
    AST_READ_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !mem_space) |-> ({1'b0, mem_addr} < (ADDR_W+1)'(REGION_BYTES))); // R6
    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (count == '0)); // R8
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count <= req_q)); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(want_q)); // R10
endmodule

// File: tb/cis_tuple_scan_bench.sv
module cis_tuple_scan_bench;
    localparam int REG  = 256;
    localparam int MAXT = 6;
    localparam int MAXL = 8;
    localparam int LW   = $clog2(MAXL + 1);
    localparam int AW   = $clog2(REG) + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [7:0]      want_code = '0;
    logic [LW-1:0]   max_len = '0;
    logic            mem_rd_en, mem_space;
    logic [AW-1:0]   mem_addr;
    logic [7:0]      mem_rdata = '0;
    logic            done, busy, found;
    logic [LW-1:0]   count;
    logic [8*MAXL-1:0] buf_data;

    logic [7:0] attr_img [REG];
    logic [7:0] com_img  [REG];

    int total = 0, fails = 0, bad_reads = 0, cyc = 0;
    logic prev_rd = 1'b0;

    logic            r_found;
    logic [LW-1:0]   r_count;
    logic [8*MAXL-1:0] r_buf;

    always #10 clk = ~clk;

    cis_tuple_scan #(.REGION_BYTES(REG), .MAX_TUPLES(MAXT), .MAX_LEN(MAXL)) u_cis_tuple_scan (
        .clk(clk), .rst_n(rst_n), .start(start), .want_code(want_code), .max_len(max_len),
        .mem_rd_en(mem_rd_en), .mem_space(mem_space), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .done(done), .busy(busy), .found(found), .count(count), .buf_data(buf_data)
    );

    // memory model: odd attribute bytes return junk
    always @(posedge clk) begin
        prev_rd <= mem_rd_en;
        if (mem_rd_en && prev_rd) bad_reads++;
        if (mem_rd_en) begin
            if (mem_space) begin
                if (mem_addr[0]) begin bad_reads++; mem_rdata <= 8'h5A; end
                else mem_rdata <= attr_img[mem_addr[AW-1:1]];
            end else begin
                if (mem_addr[AW-1]) begin bad_reads++; mem_rdata <= 8'h5A; end
                else mem_rdata <= com_img[mem_addr[AW-2:0]];
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; fails++;
            $display("FAIL watchdog actual %0d expected <150000 cycles", cyc);
            summary();
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wipe();
        for (int i = 0; i < REG; i++) begin attr_img[i] = 8'hFF; com_img[i] = 8'hFF; end
        bad_reads = 0;
    endtask

    task automatic run_scan(input logic [7:0] code, input logic [LW-1:0] len);
        int w;
        @(negedge clk);
        want_code = code; max_len = len; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done && w < 5000) begin @(negedge clk); w++; end
        check(done, "R9 done seen", int'(done), 1);
        r_found = found; r_count = count; r_buf = buf_data;
        @(negedge clk);
        check(!done && !busy, "R9 done one cycle", int'(done), 0);
        check(found == r_found && count == r_count && buf_data == r_buf, "R9 results held",
              int'(count), int'(r_count));
        check(bad_reads == 0, "R3 R6 R11 read discipline", bad_reads, 0);
    endtask

    task automatic expect_res(input string tag, input logic f, input int n, input logic [8*MAXL-1:0] b);
        check(r_found == f, {tag, " found"}, int'(r_found), int'(f));
        check(int'(r_count) == n, {tag, " count"}, int'(r_count), n);
        check(r_buf == b, {tag, " bytes"}, int'(r_buf[31:0]), int'(b[31:0]));
    endtask

    task automatic t_reset();
        check(!done && !busy && !found && count == 0 && !mem_rd_en && buf_data == '0,
              "R12 reset state", int'({done, busy, found, mem_rd_en}), 0);
    endtask

    task automatic t_first_match();  // R1 R3 R7
        wipe();
        attr_img[0] = 8'h10; attr_img[1] = 8'd3;
        attr_img[2] = 8'hA1; attr_img[3] = 8'hB2; attr_img[4] = 8'hC3;
        run_scan(8'h10, 4'd8);
        expect_res("R1 R3 first tuple", 1'b1, 3, 64'h0000_0000_00C3_B2A1);
    endtask

    task automatic t_chain_trunc();  // R1 R7 request truncation
        wipe();
        attr_img[0] = 8'h01; attr_img[1] = 8'd2; attr_img[2] = 8'h15; attr_img[3] = 8'h00;
        attr_img[4] = 8'h15; attr_img[5] = 8'd4;
        attr_img[6] = 8'h11; attr_img[7] = 8'h22; attr_img[8] = 8'h33; attr_img[9] = 8'h44;
        run_scan(8'h15, 4'd2);
        expect_res("R1 R7 chain skip", 1'b1, 2, 64'h2211);
    endtask

    task automatic t_fallback();  // R4
        wipe();
        attr_img[0] = 8'h01; attr_img[1] = 8'd1; attr_img[2] = 8'h20;
        com_img[0] = 8'h03; com_img[1] = 8'd0;
        com_img[2] = 8'h20; com_img[3] = 8'd2; com_img[4] = 8'h9C; com_img[5] = 8'h7E;
        run_scan(8'h20, 4'd8);
        expect_res("R4 common fallback", 1'b1, 2, 64'h7E9C);
    endtask

    task automatic t_miss();  // R8
        wipe();
        attr_img[0] = 8'h01; attr_img[1] = 8'd0;
        com_img[0]  = 8'h02; com_img[1]  = 8'd1; com_img[2] = 8'h33;
        run_scan(8'h33, 4'd8);
        expect_res("R8 miss both", 1'b0, 0, '0);
    endtask

    task automatic t_link_end();  // R2
        wipe();
        attr_img[0] = 8'h30; attr_img[1] = 8'hFF; attr_img[2] = 8'h30; attr_img[3] = 8'd1;
        run_scan(8'h30, 4'd8);
        expect_res("R2 link end marker", 1'b0, 0, '0);
        wipe();
        attr_img[0] = 8'hFF; attr_img[1] = 8'd1; attr_img[2] = 8'h31; attr_img[3] = 8'd0;
        run_scan(8'h31, 4'd8);
        expect_res("R2 code end marker", 1'b0, 0, '0);
    endtask

    task automatic t_tuple_limit();  // R5
        wipe();
        for (int i = 0; i < MAXT; i++) begin attr_img[2*i] = 8'h01; attr_img[2*i+1] = 8'd0; end
        attr_img[2*MAXT] = 8'h44; attr_img[2*MAXT+1] = 8'd1; attr_img[2*MAXT+2] = 8'hEE;
        run_scan(8'h44, 4'd8);
        expect_res("R5 beyond tuple limit", 1'b0, 0, '0);
        wipe();
        for (int i = 0; i < MAXT-1; i++) begin attr_img[2*i] = 8'h01; attr_img[2*i+1] = 8'd0; end
        attr_img[2*MAXT-2] = 8'h44; attr_img[2*MAXT-1] = 8'd1; attr_img[2*MAXT] = 8'hEE;
        run_scan(8'h44, 4'd8);
        expect_res("R5 last allowed tuple", 1'b1, 1, 64'hEE);
    endtask

    task automatic t_region();  // R6
        wipe();
        com_img[0] = 8'h02; com_img[1] = 8'd248;
        com_img[250] = 8'h40; com_img[251] = 8'd10;
        com_img[252] = 8'h01; com_img[253] = 8'h02; com_img[254] = 8'h03; com_img[255] = 8'h04;
        run_scan(8'h40, 4'd8);
        expect_res("R6 body cut at region end", 1'b1, 4, 64'h0403_0201);
        wipe();
        com_img[0] = 8'h02; com_img[1] = 8'd253; com_img[255] = 8'h50;
        run_scan(8'h50, 4'd8);
        expect_res("R6 link beyond region", 1'b0, 0, '0);
    endtask

    task automatic t_lengths();  // R7
        wipe();
        attr_img[0] = 8'h60; attr_img[1] = 8'd12;
        for (int i = 0; i < 12; i++) attr_img[2+i] = 8'(8'h80 + i);
        run_scan(8'h60, 4'd0);
        expect_res("R7 zero request", 1'b1, 0, '0);
        run_scan(8'h60, 4'd15);
        expect_res("R7 clamp to MAX_LEN", 1'b1, 8, 64'h8786_8584_8382_8180);
    endtask

    task automatic t_start_busy();  // R10
        wipe();
        attr_img[0] = 8'h01; attr_img[1] = 8'd0; attr_img[2] = 8'h01; attr_img[3] = 8'd0;
        attr_img[4] = 8'h11; attr_img[5] = 8'd1; attr_img[6] = 8'hC3;
        @(negedge clk);
        want_code = 8'h11; max_len = 4'd8; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        want_code = 8'h01; max_len = 4'd0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        check(found && count == 1 && buf_data[7:0] == 8'hC3, "R10 start while busy ignored",
              int'(count), 1);
        @(negedge clk);
    endtask

    initial begin
        wipe();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_match();
        t_chain_trunc();
        t_fallback();
        t_miss();
        t_link_end();
        t_tuple_limit();
        t_region();
        t_lengths();
        t_start_busy();
        summary();
    end
endmodule